// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block turns internal requests into cycles on an external bus with separate address and data lines. Each request names one of several address windows. Every window has its own configuration word, which sets the data width, the wait states, the optional setup delay and release cycles, early write-strobe release, READY handshaking, and whether a turnaround cycle is needed when the bus moves to another window. Window decoding happens upstream, so a request carries the window index. The block asserts that window's chip select, drives the address, byte enables, the read or write strobe and the write data, and returns a response. A read response carries the data captured from the bus.

One request is open at a time. `req_ready` is high only in the idle phase. The configuration is captured when a request is accepted, so writing the configuration during an access does not change the cycle in progress. On a narrow (8-bit) window, a full-word request becomes two byte cycles. A request to a window that is switched off, has a reserved width code, or has no byte enables gets an error response and causes no bus activity.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, every window's configuration reads 0, no chip select or strobe is active, `bus_oe` is low, `rsp_valid` is low and `req_ready` is high.
- R2: A configuration write stores the 12-bit word for the selected window, and `cfg_rdata` returns it. Field layout: bits 3:0 wait count, bit 4 READY mode, bit 5 setup delay, bit 6 release cycle, bit 7 early write release, bits 9:8 width code, bit 10 enable, bit 11 turnaround on exit.
- R3: A request is answered with an error response, with `rsp_rdata` = 0, in the cycle after acceptance, and it causes no chip select or strobe, if any of these holds: the window's enable bit is 0, bit 8 of its width code is 1 (reserved), or `req_be` is 00.
- R4: In counted mode, an access shows one setup cycle, then W+1 strobe cycles (W = wait count), then one hold cycle, with chip select active in all of them. Read data is taken from `bus_din` in the last strobe cycle. `rsp_valid` pulses in the cycle after the access ends.
- R5: With the setup-delay bit set, the setup phase lasts two cycles instead of one.
- R6: With the release bit set, one cycle with no chip select, strobe or `bus_oe` follows the hold cycle, before the response.
- R7: A standard write keeps `bus_wr` active through the strobe cycles and the hold cycle. With early write release set, `bus_wr` is inactive in the hold cycle while the chip select and data stay driven.
- R8: In READY mode, the strobe stays active until `bus_ready`, passed through two flip-flops, is seen high. `bus_ready` raised during strobe cycle k gives a strobe of k+2 cycles.
- R9: Width code 10 selects a 16-bit bus: one cycle, `bus_be` equal to `req_be`, and the full word on `bus_dout`, with a read returning all of `bus_din`. Width code 00 selects an 8-bit bus: `bus_be` = 01, data on bits 7:0, and bits 15:8 of `bus_dout` are zero.
- R10: On an 8-bit window, `req_be` = 11 makes two complete byte cycles, the low byte at `req_addr` and then the high byte at `req_addr`+1. `req_be` = 10 makes a single cycle at `req_addr`+1 that carries the high byte. `req_be` = 01 makes a single cycle at `req_addr` that carries the low byte.
- R11: When an accepted request targets a different window than the last completed access, and that previous window had its turnaround bit set at the time of its access, one cycle with everything inactive is inserted before the setup. If the bit was clear, or the window is the same, no cycle is inserted.
- R12: At most one chip select is active at a time. `bus_oe` is high only in the setup, strobe and hold cycles of a write. Strobes and `bus_oe` never occur without a chip select, and `bus_rd` and `bus_wr` are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SELW | Window selected for a configuration write or read |
| cfg_wdata | input | 12 | Configuration word to write |
| cfg_rdata | output | 12 | Configuration word of the selected window |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle (idle) |
| req_win | input | SELW | Target window index |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables (bit 0 low byte) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 16 | Read data |
| bus_addr | output | AW | External address |
| bus_cs | output | NWIN | Per-window chip selects, active high |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_be | output | 2 | External byte enables |
| bus_dout | output | 16 | Write data to the bus |
| bus_oe | output | 1 | Data output enable |
| bus_din | input | 16 | Read data from the bus |
| bus_ready | input | 1 | Asynchronous external READY |

## Verification
A wrong phase register or wrong wait count shows up at the chip select and strobe pins in the same cycle it occurs. A strobe that is one cycle too long or too short is visible at its falling edge, and read data captured in the wrong cycle appears in the response one cycle after the access. A corrupted record of the last window or its turnaround bit stays hidden until the next request to a different window, and then shows as an extra or missing idle cycle before the setup. A bad configuration snapshot shows as wrong strobe timing or byte lanes during the access that took it.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  localparam int CFG_W  = 12;
  localparam int WAIT_W = 4;

  typedef struct packed {
    logic              swc;       // 11: turnaround when leaving
    logic              active;    // 10: window enable
    logic [1:0]        width;     // 9:8: 00 byte, 10 word, x1 reserved
    logic              early_wr;  // 7
    logic              rel;       // 6: release cycle after hold
    logic              dly;       // 5: extra setup cycle
    logic              rdy_en;    // 4: READY handshaking
    logic [WAIT_W-1:0] wait_n;    // 3:0
  } win_cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_TURN, PH_SETUP, PH_DELAY, PH_STROBE, PH_HOLD, PH_REL
  } phase_t;

  function automatic logic cfg_rejects(win_cfg_t c, logic [1:0] be);
    return !c.active || c.width[0] || (be == 2'b00);
  endfunction

  function automatic logic is_narrow(win_cfg_t c);
    return c.width == 2'b00;
  endfunction

  function automatic logic needs_split(win_cfg_t c, logic [1:0] be);
    return is_narrow(c) && (be == 2'b11);
  endfunction

  function automatic logic needs_turn(logic have_last, logic last_swc, logic same_win);
    return have_last && last_swc && !same_win;
  endfunction
endpackage

// File: rtl/ebs_cfg_bank.sv
module ebs_cfg_bank import ebs_pkg::*; #(
  parameter int NWIN = 4,
  localparam int SELW = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SELW-1:0]  sel,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  input  logic [SELW-1:0]  req_win,
  output win_cfg_t         req_cfg
);
  win_cfg_t regs [NWIN];

  for (genvar g = 0; g < NWIN; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            regs[g] <= '0;
      else if (we && (sel == SELW'(g)))      regs[g] <= win_cfg_t'(wdata);
    end
  end

  assign rdata   = regs[sel];
  assign req_cfg = regs[req_win];
endmodule

// File: rtl/ebs_sync2.sv
module ebs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] stg;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= 2'b00;
    else        stg <= {stg[0], d};
  end
  assign q = stg[1];
endmodule

// File: rtl/ebs_seq.sv
module ebs_seq import ebs_pkg::*; #(
  parameter int NWIN = 4,
  parameter int AW   = 16,
  localparam int SELW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [SELW-1:0] req_win,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic [1:0]      req_be,
  input  logic [15:0]     req_wdata,
  input  win_cfg_t        req_cfg,
  output logic            req_ready,
  output logic            rsp_valid,
  output logic            rsp_err,
  output logic [15:0]     rsp_rdata,
  output logic [AW-1:0]   bus_addr,
  output logic [NWIN-1:0] bus_cs,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic [1:0]      bus_be,
  output logic [15:0]     bus_dout,
  output logic            bus_oe,
  input  logic [15:0]     bus_din,
  input  logic            rdy_s,
  output win_cfg_t        act_cfg,
  output logic            strobe_phase,
  output logic            turn_cycle
);
  phase_t            phase;
  win_cfg_t          cfg_q;
  logic [SELW-1:0]   win_q, last_win;
  logic [AW-1:0]     addr_q;
  logic              wr_q, hi_byte, split_q, have_last, last_swc;
  logic [1:0]        be_q;
  logic [15:0]       wdata_q, rdata_q;
  logic [WAIT_W-1:0] cnt;
  logic              rsp_v_q, rsp_e_q;

  // named internal events
  logic drive, narrow, strobe_done, byte_end, reject_now;
  assign drive       = (phase == PH_SETUP) || (phase == PH_DELAY) ||
                       (phase == PH_STROBE) || (phase == PH_HOLD);
  assign narrow      = is_narrow(cfg_q);
  assign strobe_done = cfg_q.rdy_en ? rdy_s : (cnt == '0);
  assign byte_end    = ((phase == PH_HOLD) && !cfg_q.rel) || (phase == PH_REL);
  assign reject_now  = cfg_rejects(req_cfg, req_be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;  cfg_q <= '0;  win_q <= '0;  last_win <= '0;
      addr_q <= '0;  wr_q <= 1'b0;  hi_byte <= 1'b0;  split_q <= 1'b0;
      have_last <= 1'b0;  last_swc <= 1'b0;  be_q <= '0;  wdata_q <= '0;
      rdata_q <= '0;  cnt <= '0;  rsp_v_q <= 1'b0;  rsp_e_q <= 1'b0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (phase)
        PH_IDLE: if (req_valid) begin
          cfg_q <= req_cfg;  win_q <= req_win;  addr_q <= req_addr;
          wr_q <= req_write;  be_q <= req_be;  wdata_q <= req_wdata;
          hi_byte <= is_narrow(req_cfg) && (req_be == 2'b10);
          split_q <= needs_split(req_cfg, req_be);
          rdata_q <= '0;
          if (reject_now) begin
            rsp_v_q <= 1'b1;  rsp_e_q <= 1'b1;
          end else if (needs_turn(have_last, last_swc, last_win == req_win)) begin
            phase <= PH_TURN;
          end else begin
            phase <= PH_SETUP;
          end
        end
        PH_TURN:  phase <= PH_SETUP;
        PH_SETUP: begin
          cnt   <= cfg_q.wait_n;
          phase <= cfg_q.dly ? PH_DELAY : PH_STROBE;
        end
        PH_DELAY: phase <= PH_STROBE;
        PH_STROBE: if (strobe_done) begin
          if (!wr_q) begin
            if (!narrow)      rdata_q       <= bus_din;
            else if (hi_byte) rdata_q[15:8] <= bus_din[7:0];
            else              rdata_q[7:0]  <= bus_din[7:0];
          end
          phase <= PH_HOLD;
        end else if (!cfg_q.rdy_en) begin
          cnt <= cnt - 1'b1;
        end
        PH_HOLD:  if (cfg_q.rel) phase <= PH_REL;
        PH_REL:   ;
        default:  phase <= PH_IDLE;
      endcase
      if (byte_end) begin
        if (split_q) begin
          split_q <= 1'b0;  hi_byte <= 1'b1;  phase <= PH_SETUP;
        end else begin
          phase <= PH_IDLE;  rsp_v_q <= 1'b1;  rsp_e_q <= 1'b0;
          have_last <= 1'b1;  last_win <= win_q;  last_swc <= cfg_q.swc;
        end
      end
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_cs
    assign bus_cs[g] = drive && (win_q == SELW'(g));
  end

  assign req_ready    = (phase == PH_IDLE);
  assign rsp_valid    = rsp_v_q;
  assign rsp_err      = rsp_e_q;
  assign rsp_rdata    = rdata_q;
  assign bus_rd       = (phase == PH_STROBE) && !wr_q;
  assign bus_wr       = wr_q && ((phase == PH_STROBE) ||
                                 ((phase == PH_HOLD) && !cfg_q.early_wr));
  assign bus_oe       = drive && wr_q;
  assign bus_addr     = addr_q + AW'(narrow && hi_byte);
  assign bus_be       = narrow ? 2'b01 : be_q;
  assign bus_dout     = narrow ? {8'h00, hi_byte ? wdata_q[15:8] : wdata_q[7:0]} : wdata_q;
  assign act_cfg      = cfg_q;
  assign strobe_phase = (phase == PH_STROBE);
  assign turn_cycle   = (phase == PH_TURN);
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq import ebs_pkg::*; #(
  parameter int NWIN = 4,
  parameter int AW   = 16,
  localparam int SELW = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SELW-1:0]  cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SELW-1:0]  req_win,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic [1:0]       req_be,
  input  logic [15:0]      req_wdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [15:0]      rsp_rdata,
  output logic [AW-1:0]    bus_addr,
  output logic [NWIN-1:0]  bus_cs,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [1:0]       bus_be,
  output logic [15:0]      bus_dout,
  output logic             bus_oe,
  input  logic [15:0]      bus_din,
  input  logic             bus_ready
);
  win_cfg_t req_cfg, act_cfg;
  logic     rdy_s, strobe_phase, turn_cycle;

  ebs_cfg_bank #(.NWIN(NWIN)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .req_win(req_win), .req_cfg(req_cfg)
  );

  ebs_sync2 u_rdy (.clk(clk), .rst_n(rst_n), .d(bus_ready), .q(rdy_s));

  ebs_seq #(.NWIN(NWIN), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_win(req_win),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .req_wdata(req_wdata), .req_cfg(req_cfg), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
    .rdy_s(rdy_s), .act_cfg(act_cfg), .strobe_phase(strobe_phase),
    .turn_cycle(turn_cycle)
  );
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
  parameter int NWIN = 4,
  localparam int SELW = $clog2(NWIN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [SELW-1:0] req_win,
  input logic [1:0]      req_be,
  input logic            req_active,
  input logic            req_wid0,
  input logic            req_swc,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic [NWIN-1:0] bus_cs,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic            bus_oe,
  input logic            strobe_phase,
  input logic            turn_cycle,
  input logic            act_rdy_en,
  input logic [3:0]      act_wait,
  input logic            rdy_s
);
  logic            rej, acc, seen, prev_swc, strobe_q, oe_q;
  logic [SELW-1:0] prev_win;
  logic [NWIN-1:0] cs_q;
  logic [5:0]      len;

  assign rej = (req_be == 2'b00) || req_wid0 || !req_active;
  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; prev_swc <= 1'b0; prev_win <= '0;
      strobe_q <= 1'b0; oe_q <= 1'b0; cs_q <= '0; len <= '0;
    end else begin
      if (acc && !rej) begin
        seen <= 1'b1; prev_swc <= req_swc; prev_win <= req_win;
      end
      strobe_q <= strobe_phase;
      oe_q     <= bus_oe;
      cs_q     <= bus_cs;
      if (!strobe_phase)      len <= '0;
      else if (len != 6'h3F)  len <= len + 1'b1;
    end
  end

  assert_cs_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_cs));
  assert_strobe_has_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr || bus_oe) |-> ((|bus_cs) && !(bus_rd && bus_wr)));
  assert_oe_same_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && oe_q) |-> (bus_cs == cs_q));
  assert_reject_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rej) |=> (rsp_valid && rsp_err && (bus_cs == '0)));
  assert_wait_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && !strobe_phase && !act_rdy_en) |-> (len == {2'b00, act_wait} + 6'd1));
  assert_ready_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_phase && act_rdy_en && !rdy_s) |=> strobe_phase);
  assert_turn_inserted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !rej && seen && prev_swc && (prev_win != req_win)) |=> turn_cycle);
  assert_turn_skipped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !rej && !(seen && prev_swc && (prev_win != req_win))) |=> !turn_cycle);
endmodule

bind ext_bus_seq ext_bus_seq_chk #(.NWIN(NWIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_win(req_win), .req_be(req_be), .req_active(req_cfg.active),
  .req_wid0(req_cfg.width[0]), .req_swc(req_cfg.swc), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_oe(bus_oe), .strobe_phase(strobe_phase), .turn_cycle(turn_cycle),
  .act_rdy_en(act_cfg.rdy_en), .act_wait(act_cfg.wait_n), .rdy_s(rdy_s)
);

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
  localparam int NW = 4;

  typedef struct packed {
    logic [NW-1:0] cs;
    logic rd, wr, oe, rsp, err, raise;
    logic [15:0] addr;
    logic [1:0]  be;
    logic [15:0] dout;
    logic [15:0] rdata;
  } vec_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [11:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [1:0] req_win = '0, req_be = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [15:0] rsp_rdata, bus_addr, bus_dout, bus_din;
  logic [NW-1:0] bus_cs;
  logic bus_rd, bus_wr, bus_oe, bus_ready = 1'b0;
  logic [1:0] bus_be;

  int checks = 0, bad = 0;
  logic [11:0] mcfg [NW];
  logic have_last = 1'b0, last_swc = 1'b0;
  logic [1:0] last_win = '0;
  vec_t q[$];

  always #4 clk = ~clk;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
  endfunction
  assign bus_din = pat(bus_addr);

  function automatic logic [11:0] mk(input logic swc, act, input logic [1:0] wid,
                                     input logic early, rel, dly, rdy, input logic [3:0] w);
    return {swc, act, wid, early, rel, dly, rdy, w};
  endfunction

  ext_bus_seq #(.NWIN(NW), .AW(16)) i_ext_bus_seq (.*);

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp(vec_t v, string tag);
    logic ok;
    checks++;
    ok = (bus_cs === v.cs) && (bus_rd === v.rd) && (bus_wr === v.wr) &&
         (bus_oe === v.oe) && (rsp_valid === v.rsp);
    if (v.cs != '0) ok = ok && (bus_addr === v.addr) && (bus_be === v.be);
    if (v.oe)       ok = ok && (bus_dout === v.dout);
    if (v.rsp)      ok = ok && (rsp_err === v.err) && (rsp_rdata === v.rdata);
    if (!ok) begin
      bad++;
      $display("FAIL %s actual cs=%b rd=%b wr=%b oe=%b addr=%h be=%b dout=%h rsp=%b err=%b rdata=%h expected cs=%b rd=%b wr=%b oe=%b addr=%h be=%b dout=%h rsp=%b err=%b rdata=%h",
               tag, bus_cs, bus_rd, bus_wr, bus_oe, bus_addr, bus_be, bus_dout, rsp_valid,
               rsp_err, rsp_rdata, v.cs, v.rd, v.wr, v.oe, v.addr, v.be, v.dout, v.rsp,
               v.err, v.rdata);
    end
  endtask

  task automatic write_cfg(input logic [1:0] idx, input logic [11:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = idx; cfg_wdata = val;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    mcfg[idx] = val;
    check_eq("R2 readback", 32'(cfg_rdata), 32'(val));
  endtask

  // Reference model: list every expected cycle, then compare cycle by cycle.
  task automatic access(string tag, input logic [1:0] win, input logic [15:0] addr,
                        input logic wr, input logic [1:0] be, input logic [15:0] wd,
                        input int rdy_at);
    logic [11:0] c;
    logic rej, narrow, hi, turn;
    logic [15:0] rdata, a, d;
    int nbytes, slen;
    vec_t off, v;
    c = mcfg[win];
    off = '0;
    rej = !c[10] || c[8] || (be == 2'b00);
    rdata = '0;
    q.delete();
    if (!rej) begin
      turn = have_last && last_swc && (last_win != win);
      if (turn) q.push_back(off);
      narrow = (c[9:8] == 2'b00);
      nbytes = (narrow && be == 2'b11) ? 2 : 1;
      for (int b = 0; b < nbytes; b++) begin
        hi = (narrow && be == 2'b10) || (b == 1);
        a = addr + 16'(narrow && hi);
        d = pat(a);
        if (!wr) begin
          if (!narrow)  rdata = d;
          else if (hi)  rdata[15:8] = d[7:0];
          else          rdata[7:0] = d[7:0];
        end
        v = off;
        v.cs = NW'(1) << win; v.addr = a; v.oe = wr;
        v.be = narrow ? 2'b01 : be;
        v.dout = narrow ? {8'h00, hi ? wd[15:8] : wd[7:0]} : wd;
        q.push_back(v);
        if (c[5]) q.push_back(v);
        slen = c[4] ? rdy_at + 2 : int'(c[3:0]) + 1;
        for (int i = 0; i < slen; i++) begin
          vec_t s = v;
          s.rd = !wr; s.wr = wr; s.raise = c[4] && (i == rdy_at - 1);
          q.push_back(s);
        end
        v.wr = wr && !c[7];
        q.push_back(v);
        if (c[6]) q.push_back(off);
      end
      have_last = 1'b1; last_win = win; last_swc = c[11];
    end
    v = off; v.rsp = 1'b1; v.err = rej; v.rdata = rdata;
    q.push_back(v);

    @(negedge clk);
    req_valid = 1'b1; req_win = win; req_addr = addr; req_write = wr;
    req_be = be; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (q.size() > 0) begin
      vec_t e = q.pop_front();
      @(negedge clk);
      cmp(e, tag);
      if (e.raise) bus_ready = 1'b1;
    end
    if (c[4]) begin
      bus_ready = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NW; i++) mcfg[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < NW; i++) begin
      cfg_sel = 2'(i); #1;
      check_eq("R1 cfg after reset", 32'(cfg_rdata), 32'h0);
    end
    check_eq("R1 idle pins", {28'h0, bus_cs}, 32'h0);
    check_eq("R1 strobes/oe/rsp/ready", {28'h0, bus_rd, bus_wr, bus_oe, rsp_valid}, 32'h0);
    check_eq("R1 ready", 32'(req_ready), 32'h1);

    access("R3 disabled window", 2'd0, 16'h0010, 1'b0, 2'b11, 16'h0, 0);

    write_cfg(2'd0, mk(1, 1, 2'b10, 0, 0, 0, 0, 4'd3));
    write_cfg(2'd1, mk(0, 1, 2'b00, 0, 0, 0, 0, 4'd1));
    write_cfg(2'd2, mk(0, 1, 2'b01, 0, 0, 0, 0, 4'd0));
    write_cfg(2'd3, mk(0, 1, 2'b10, 1, 1, 1, 0, 4'd0));

    access("R3 reserved width", 2'd2, 16'h0020, 1'b0, 2'b11, 16'h0, 0);
    access("R3 no byte enable", 2'd0, 16'h0030, 1'b1, 2'b00, 16'h1234, 0);
    access("R4 counted read", 2'd0, 16'h1230, 1'b0, 2'b11, 16'h0, 0);
    access("R9 word write", 2'd0, 16'h1240, 1'b1, 2'b10, 16'hBEEF, 0);
    access("R11 turnaround to byte window", 2'd1, 16'h0040, 1'b0, 2'b01, 16'h0, 0);
    access("R10 split read", 2'd1, 16'h0050, 1'b0, 2'b11, 16'h0, 0);
    access("R10 split write", 2'd1, 16'h0058, 1'b1, 2'b11, 16'hA1B2, 0);
    access("R10 high byte read", 2'd1, 16'h0060, 1'b0, 2'b10, 16'h0, 0);
    access("R11 no turnaround R7 early write", 2'd3, 16'h0300, 1'b1, 2'b11, 16'h5A5A, 0);
    access("R5 R6 delay and release read", 2'd3, 16'h0310, 1'b0, 2'b11, 16'h0, 0);
    write_cfg(2'd0, mk(1, 1, 2'b10, 0, 0, 0, 0, 4'd2));
    access("R7 standard write", 2'd0, 16'h0400, 1'b1, 2'b11, 16'hC0DE, 0);
    write_cfg(2'd1, mk(1, 1, 2'b10, 0, 0, 0, 1, 4'd0));
    access("R8 ready read", 2'd1, 16'h0500, 1'b0, 2'b11, 16'h0, 2);
    access("R12 write after turnaround", 2'd0, 16'h0600, 1'b1, 2'b01, 16'h7E81, 0);
    access("R11 same window", 2'd0, 16'h0608, 1'b0, 2'b11, 16'h0, 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule